// File: doc/BRIEF.md
# Multi-line external interrupt sense and gating unit

This block watches a set of external interrupt wires, up to 32 of them, and turns activity on each wire into a latched detect flag. Each wire has its own programmable sense mode. A mode can detect a level (low or high), or it can detect an edge (falling, rising or both). Edges are found synchronously by comparing successive samples taken after a multi-flop synchroniser. Each detect flag is ANDed with a per-line enable bit, and the result drives one dedicated request output per line toward a parent interrupt controller.

Software reaches the block through a plain 32-bit register bus with address, write strobe, write data and combinational read data. There are two separate write-one registers: one turns enables on and the other turns them off. The detect flags are read and cleared through a write-one-to-clear status word. Every line also has its own 32-bit configuration word, and the sense mode sits in the low bits of that word.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every line is disabled, every detect flag is clear, every configuration word reads 0, and every request output is low.
- R2: A write to offset 0x008 sets the enable of each line whose data bit is 1. Bits written as 0 leave the corresponding enables unchanged.
- R3: A write to offset 0x004 clears the enable of each line whose data bit is 1. Bits written as 0 have no effect. A read of 0x004 returns the enable mask, with bit n belonging to line n.
- R4: Line n owns a 32-bit configuration word at offset 0x180 + 4·n. That word reads back exactly what was last written to it. Bits [5:0] are the sense code, and a code with none of bits [3:0] set detects nothing.
- R5: Request output n is high exactly when detect flag n and enable n are both 1. A read of offset 0x000 returns this masked vector.
- R6: Level modes use code 0x02 (high) and code 0x01 (low). The flag sets while the line is at its active level. A clear issued while the level is still active leaves the flag set. Once the level is inactive, a clear removes the flag.
- R7: Rising-edge mode uses code 0x08. A 0→1 change on the input becomes visible in the status word after the third rising clock edge following the change, and not before.
- R8: Falling-edge mode uses code 0x04, and both-edges mode uses code 0x0C. Each sets the flag on the matching transitions only.
- R9: The detect status word at offset 0x100 shows flag n in bit n. Writing 1 to a bit clears that flag, and writing 0 has no effect. A detection in the same cycle as a clear wins, so the flag stays set.
- R10: An edge-detected flag stays latched after the input returns to its idle level, including after a one-cycle pulse.
- R11: Unmapped offsets read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | LINES | External interrupt wires, asynchronous |
| irq_out | output | LINES | Per-line masked request toward the parent controller |

## Verification
The assertions assume that each bus write lasts exactly one clock cycle. They also assume that the address is a byte offset that is only meaningful when word-aligned, and that no bits above LINES-1 carry meaning. The stimulus drives writes as one-cycle strobes on aligned offsets. It changes the input wires only away from the clock edge and holds each level for at least one full cycle. Before each edge test, the line's sense code is set to 0 and its input is settled at the idle level, so the sample history is real before detection is switched on.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   localparam int unsigned BUS_W        = 32;
   localparam int unsigned SENSE_W      = 6;

   // register byte offsets decoded by software
   localparam int unsigned OFS_PEND     = 'h000;
   localparam int unsigned OFS_EN_OFF   = 'h004;
   localparam int unsigned OFS_EN_ON    = 'h008;
   localparam int unsigned OFS_FLAGS    = 'h100;
   localparam int unsigned OFS_CFG_BASE = 'h180;
   localparam int unsigned CFG_STRIDE   = 4;

   typedef struct packed {
      logic rise;
      logic fall;
      logic lvl_hi;
      logic lvl_lo;
   } sense_t;

   function automatic sense_t decode_sense(input logic [SENSE_W-1:0] code);
      sense_t s;
      s.lvl_lo = code[0];
      s.lvl_hi = code[1];
      s.fall   = code[2];
      s.rise   = code[3];
      return s;
   endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int unsigned LINES  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] raw,
   output logic [LINES-1:0] cur,
   output logic [LINES-1:0] last,
   output logic             hist_ok
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ext_irq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [LINES-1:0] stg [STAGES];
   logic [STAGES:0]  fill_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= raw;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last   <= '0;
         fill_q <= '0;
      end else begin
         last   <= stg[STAGES-1];
         fill_q <= {fill_q[STAGES-1:0], 1'b1};
      end
   end

   assign cur     = stg[STAGES-1];
   assign hist_ok = fill_q[STAGES];

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
   import ext_irq_pkg::*;
#(
   parameter int unsigned LINES = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [LINES-1:0]                cur,
   input  logic [LINES-1:0]                last,
   input  logic                            hist_ok,
   input  logic [LINES-1:0][SENSE_W-1:0]   sense,
   input  logic [LINES-1:0]                clr,
   output logic [LINES-1:0]                flag
);

   generate
      for (genvar n = 0; n < LINES; n++) begin : g_line
         sense_t s;
         logic   hit;

         assign s   = decode_sense(sense[n]);
         assign hit = (s.lvl_hi &  cur[n])
                    | (s.lvl_lo & ~cur[n])
                    | (hist_ok & s.rise &  cur[n] & ~last[n])
                    | (hist_ok & s.fall & ~cur[n] &  last[n]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag[n] <= 1'b0;
            else        flag[n] <= hit | (flag[n] & ~clr[n]);
         end
      end
   endgenerate

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
   import ext_irq_pkg::*;
#(
   parameter int unsigned LINES  = 32,
   parameter int unsigned ADDR_W = 12
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic                           bus_we,
   input  logic [BUS_W-1:0]               bus_wdata,
   output logic [BUS_W-1:0]               bus_rdata,
   input  logic [LINES-1:0]               flag,
   input  logic [LINES-1:0]               pend,
   output logic [LINES-1:0]               en_q,
   output logic [LINES-1:0][SENSE_W-1:0]  sense,
   output logic [LINES-1:0]               clr
);

   logic [LINES-1:0][BUS_W-1:0] cfg_q;
   logic [LINES-1:0]            cfg_sel;
   logic [LINES-1:0]            wmask;
   logic                        sel_pend, sel_off, sel_on, sel_flags;

   assign wmask     = bus_wdata[LINES-1:0];
   assign sel_pend  = (bus_addr == ADDR_W'(OFS_PEND));
   assign sel_off   = (bus_addr == ADDR_W'(OFS_EN_OFF));
   assign sel_on    = (bus_addr == ADDR_W'(OFS_EN_ON));
   assign sel_flags = (bus_addr == ADDR_W'(OFS_FLAGS));
   assign clr       = (bus_we && sel_flags) ? wmask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (bus_we) begin
         if (sel_on)  en_q <= en_q | wmask;
         if (sel_off) en_q <= en_q & ~wmask;
      end
   end

   generate
      for (genvar n = 0; n < LINES; n++) begin : g_cfg
         assign cfg_sel[n] = (bus_addr == ADDR_W'(OFS_CFG_BASE + CFG_STRIDE * n));
         assign sense[n]   = cfg_q[n][SENSE_W-1:0];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    cfg_q[n] <= '0;
            else if (bus_we && cfg_sel[n]) cfg_q[n] <= bus_wdata;
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (sel_pend)  bus_rdata = BUS_W'(pend);
      if (sel_off)   bus_rdata = BUS_W'(en_q);
      if (sel_flags) bus_rdata = BUS_W'(flag);
      for (int n = 0; n < LINES; n++) begin
         if (cfg_sel[n]) bus_rdata = cfg_q[n];
      end
   end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import ext_irq_pkg::*;
#(
   parameter int unsigned LINES       = 32,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [LINES-1:0]   irq_in,
   output logic [LINES-1:0]   irq_out
);

   localparam int unsigned TOP_OFS = OFS_CFG_BASE + CFG_STRIDE * LINES;

   generate
      if (LINES < 1 || LINES > BUS_W) begin : g_bad_lines
         $error("ext_irq_ctrl: LINES must lie in 1..32");
      end
      if ((1 << ADDR_W) < TOP_OFS) begin : g_bad_addr
         $error("ext_irq_ctrl: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [LINES-1:0]              cur, last, flag_q, en_q, clr;
   logic [LINES-1:0][SENSE_W-1:0] sense_q;
   logic                          hist_ok;

   ext_irq_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (irq_in),
      .cur     (cur),
      .last    (last),
      .hist_ok (hist_ok)
   );

   ext_irq_detect #(.LINES(LINES)) i_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .cur     (cur),
      .last    (last),
      .hist_ok (hist_ok),
      .sense   (sense_q),
      .clr     (clr),
      .flag    (flag_q)
   );

   ext_irq_regs #(.LINES(LINES), .ADDR_W(ADDR_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .flag      (flag_q),
      .pend      (irq_out),
      .en_q      (en_q),
      .sense     (sense_q),
      .clr       (clr)
   );

   assign irq_out = flag_q & en_q;

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
   import ext_irq_pkg::*;
#(
   parameter int unsigned LINES  = 32,
   parameter int unsigned ADDR_W = 12
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [ADDR_W-1:0]              bus_addr,
   input logic                           bus_we,
   input logic [31:0]                    bus_wdata,
   input logic [LINES-1:0]               irq_out,
   input logic [LINES-1:0]               en_q,
   input logic [LINES-1:0]               flag_q,
   input logic [LINES-1:0][SENSE_W-1:0]  sense_q
);

   logic wr_on, wr_off, wr_flags;
   assign wr_on    = bus_we && (bus_addr == ADDR_W'(OFS_EN_ON));
   assign wr_off   = bus_we && (bus_addr == ADDR_W'(OFS_EN_OFF));
   assign wr_flags = bus_we && (bus_addr == ADDR_W'(OFS_FLAGS));

   p_out_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & ~en_q) == '0);

   p_out_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & ~flag_q) == '0);

   p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_on |=> ((en_q & $past(bus_wdata[LINES-1:0])) == $past(bus_wdata[LINES-1:0])));

   p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_off |=> ((en_q & $past(bus_wdata[LINES-1:0])) == '0));

   p_en_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_on || wr_off) |=> $stable(en_q));

   generate
      for (genvar n = 0; n < LINES; n++) begin : g_line
         p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (sense_q[n][3:0] == 4'd0 && !flag_q[n]) |=> !flag_q[n]);

         p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_flags && bus_wdata[n] && sense_q[n][3:0] == 4'd0) |=> !flag_q[n]);
      end
   endgenerate

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .irq_out   (irq_out),
   .en_q      (en_q),
   .flag_q    (flag_q),
   .sense_q   (sense_q)
);

// File: tb/test_ext_irq_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_ctrl;

   localparam int unsigned LINES  = 32;
   localparam int unsigned ADDR_W = 12;
   localparam int unsigned TL     = 3;

   // {sense code, input pattern (bit7 first), expected flag}
   localparam logic [23:0] VEC [16] = '{
      {8'h08, 8'b0000_1111, 8'd1},
      {8'h08, 8'b1111_0000, 8'd0},
      {8'h04, 8'b1111_0000, 8'd1},
      {8'h04, 8'b0000_1111, 8'd0},
      {8'h0C, 8'b0000_1111, 8'd1},
      {8'h0C, 8'b1111_0000, 8'd1},
      {8'h08, 8'b0010_0000, 8'd1},
      {8'h04, 8'b1101_1111, 8'd1},
      {8'h02, 8'b0000_1111, 8'd1},
      {8'h02, 8'b0010_0000, 8'd1},
      {8'h02, 8'b0000_0000, 8'd0},
      {8'h01, 8'b1111_0000, 8'd1},
      {8'h01, 8'b1111_1111, 8'd0},
      {8'h00, 8'b0000_1111, 8'd0},
      {8'h30, 8'b0000_1111, 8'd0},
      {8'h04, 8'b0000_0000, 8'd0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_we = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [LINES-1:0]  irq_in = '0;
   logic [LINES-1:0]  irq_out;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ext_irq_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W)) i_ext_irq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_in    (irq_in),
      .irq_out   (irq_out)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int unsigned a, input logic [31:0] d);
      bus_addr  = ADDR_W'(a);
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
      bus_wdata = '0;
   endtask

   task automatic rd(input int unsigned a, output logic [31:0] d);
      bus_addr = ADDR_W'(a);
      #0.5;
      d = bus_rdata;
   endtask

   function automatic int unsigned cfg(input int unsigned n);
      return 'h180 + 4 * n;
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd('h000, r); check(r, 0, "R1 pending");
      rd('h004, r); check(r, 0, "R1 enables");
      rd('h100, r); check(r, 0, "R1 flags");
      rd(cfg(0), r); check(r, 0, "R1 cfg0");
      rd(cfg(31), r); check(r, 0, "R1 cfg31");
      check(irq_out, 0, "R1 irq_out");

      // vector table on line TL: R6 R7 R8 R10 R4
      for (int v = 0; v < 16; v++) begin
         logic [7:0] code, pat, exp;
         {code, pat, exp} = VEC[v];
         wr(cfg(TL), 0);
         irq_in[TL] = pat[7];
         repeat (5) @(negedge clk);
         wr(cfg(TL), 32'(code));
         wr('h100, 32'(1) << TL);
         for (int i = 6; i >= 0; i--) begin
            irq_in[TL] = pat[i];
            @(negedge clk);
         end
         repeat (4) @(negedge clk);
         rd('h100, r);
         check(32'(r[TL]), 32'(exp[0]), $sformatf("R8 R10 vector %0d code %h", v, code));
      end
      wr(cfg(TL), 0);
      irq_in[TL] = 1'b0;
      repeat (4) @(negedge clk);
      wr('h100, 32'hFFFF_FFFF);

      // R2 and R3 enables
      wr('h008, 32'h0000_00A5); rd('h004, r); check(r, 32'hA5, "R2 set");
      wr('h008, 0);             rd('h004, r); check(r, 32'hA5, "R2 zeros");
      wr('h004, 32'h0000_0005); rd('h004, r); check(r, 32'hA0, "R3 clear");
      wr('h004, 0);             rd('h004, r); check(r, 32'hA0, "R3 zeros");

      // R4 full-word readback
      wr(cfg(5), 32'hABCD_1208); rd(cfg(5), r); check(r, 32'hABCD_1208, "R4 readback");
      rd(cfg(6), r); check(r, 0, "R4 neighbour");
      wr(cfg(6), 32'h0000_0008);

      // R5 masking
      irq_in[5] = 1'b1; irq_in[6] = 1'b1;
      repeat (4) @(negedge clk);
      rd('h100, r); check(r & 32'h60, 32'h60, "R7 flags 5 6");
      rd('h000, r); check(r, 32'h20, "R5 pending read");
      check(irq_out, 32'h20, "R5 irq_out");
      wr('h008, 32'h40);
      check(irq_out, 32'h60, "R5 after enable");

      // R7 latency
      wr(cfg(9), 32'h08);
      irq_in[9] = 1'b1;
      @(negedge clk); @(negedge clk);
      rd('h100, r); check(32'(r[9]), 0, "R7 too early");
      @(negedge clk);
      rd('h100, r); check(32'(r[9]), 1, "R7 third edge");

      // R9 write-one-to-clear
      wr('h100, 0); rd('h100, r); check(r, 32'h260, "R9 zeros");
      wr('h100, 32'h20); rd('h100, r); check(r, 32'h240, "R9 clear one");
      wr(cfg(10), 32'h08);
      irq_in[10] = 1'b1;
      @(negedge clk); @(negedge clk);
      wr('h100, 32'h400);
      rd('h100, r); check(32'(r[10]), 1, "R9 set wins");
      wr('h100, 32'h400);
      rd('h100, r); check(32'(r[10]), 0, "R9 later clear");

      // R6 level clear behaviour
      wr(cfg(11), 32'h02);
      irq_in[11] = 1'b1;
      repeat (4) @(negedge clk);
      wr('h100, 32'h800);
      rd('h100, r); check(32'(r[11]), 1, "R6 active clear");
      irq_in[11] = 1'b0;
      repeat (4) @(negedge clk);
      wr('h100, 32'h800);
      rd('h100, r); check(32'(r[11]), 0, "R6 inactive clear");

      // R11 unmapped
      rd('h00C, r); check(r, 0, "R11 0x00C");
      rd('h010, r); check(r, 0, "R11 0x010");
      rd('h104, r); check(r, 0, "R11 0x104");
      rd('h17C, r); check(r, 0, "R11 0x17C");
      wr('h010, 32'hFFFF_FFFF);
      rd('h004, r); check(r, 32'hE0, "R11 write ignored");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule